// File: doc/BRIEF.md
# RC Slope Voltage Converter Sequencer

This block measures an unknown voltage using only an external resistor, a capacitor and a comparator. It drives one output pin that charges the capacitor when high and discharges it when low. The comparator reports whether the capacitor voltage is above the unknown voltage. The block samples that bit at a fixed interval and counts samples until the bit changes state. That count selects an entry in a lookup table of voltage codes.

A conversion runs in two phases. In the charge phase the pin is high, and the count taken when the comparator first reads high addresses the lower half of the table. If the charge phase times out, the pin stays high for a settle wait so the capacitor is fully charged. The pin then goes low and the discharge phase begins. In that phase the count taken when the comparator first reads low addresses the upper half of the table. Once the result is captured, the pin is held low for a settle wait so the capacitor is empty again. Only then does the block pulse `done_o` and present the index and table value. The table is a ROM whose contents are computed from parameters.

Top module: `rc_slope_adc`

## Requirements
- R1: While reset is low, and afterwards, `charge_o` and `done_o` are low and `index_o` and `value_o` are zero. After reset the pin stays low for SETTLE_CYCLES cycles, and a start pulse during that wait is ignored.
- R2: A start pulse while idle raises `charge_o` at the next edge. Sample k (counting from 0) is taken PAD_CYCLES + k*SAMPLE_CYCLES cycles after the rise. The comparator passes through a two-flop synchroniser first. If sample k reads high, the index is k and the pin falls at that same sample.
- R3: If NUM_SAMPLES charge samples read low, the pin stays high for SETTLE_CYCLES more cycles. It then falls and the discharge phase starts with the count cleared. The pin is therefore high for PAD_CYCLES + (NUM_SAMPLES-1)*SAMPLE_CYCLES + SETTLE_CYCLES cycles in total.
- R4: In the discharge phase, sample k is taken PAD_CYCLES + k*SAMPLE_CYCLES cycles after the fall. If it reads low, the index is NUM_SAMPLES + k.
- R5: If NUM_SAMPLES discharge samples also read high, the index is 2*NUM_SAMPLES-1, the last table entry.
- R6: After the capturing sample, the pin is held low for exactly SETTLE_CYCLES cycles. `done_o` rises at the next edge after that.
- R7: `done_o` is high for exactly one cycle. `index_o` and `value_o` change only in the cycle `done_o` is high, and they hold until the next done.
- R8: `value_o` equals (ENTRY_BASE + index*ENTRY_STEP) modulo 2^DATA_W, where index is the presented index.
- R9: A start pulse while a conversion is in progress is ignored. Pin timing and the result are the same as without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a conversion (taken only when idle) |
| comp_i | input | 1 | Raw comparator output, high when the capacitor is above the unknown voltage |
| charge_o | output | 1 | Capacitor drive pin: high charges, low discharges |
| done_o | output | 1 | One-cycle strobe marking a new result |
| index_o | output | IDX_W | Table index of the last conversion |
| value_o | output | DATA_W | Table entry of the last conversion |

## Verification
The bench builds the block with NUM_SAMPLES=5, SAMPLE_CYCLES=10, PAD_CYCLES=4, SETTLE_CYCLES=30, DATA_W=8, ENTRY_BASE=7 and ENTRY_STEP=29. With these values every one of the ten table indices can be reached in a few hundred cycles. The entry step makes upper entries wrap modulo 256. A comparator model switches midway between sample instants, so the bench sweeps the trip sample over every position in both phases and also covers the double timeout. Short settle waits let the bench count exact pin-high and pin-low durations, and let it inject start pulses during both the power-up wait and a busy conversion.

// File: rtl/adc_seq_pkg.sv
// Shared types for the RC slope converter.
// Assumes nothing beyond the states listed; all widths live in the modules.
package adc_seq_pkg;
    typedef enum logic [2:0] {
        SQ_POWERUP   = 3'd0,  // pin low, waiting for the capacitor to empty
        SQ_IDLE      = 3'd1,  // waiting for start
        SQ_CHARGE    = 3'd2,  // pin high, sampling for a rising trip
        SQ_TOPUP     = 3'd3,  // pin high, charge settle after timeout
        SQ_DRAIN     = 3'd4,  // pin low, sampling for a falling trip
        SQ_EMPTY     = 3'd5   // pin low, final settle before done
    } seq_state_t;

    // Return the larger of two integers (used for counter sizing).
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/adc_sync2.sv
// Two-flop synchroniser for the asynchronous comparator bit.
// Assumes the input may change at any time; output lags by two edges.
module adc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;

    // Shift the raw bit through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_o <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/adc_tick_timer.sv
// Down-counter shared by padding, sample interval and settle waits.
// Loading value V makes zero_o true V edges later; the counter parks at zero.
// Assumes RST_VAL fits in W bits.
module adc_tick_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_TMR_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o); // R6
endmodule

// File: rtl/adc_value_rom.sv
// Computed lookup table: entry i = (BASE + i*STEP) mod 2^DATA_W.
// Assumes addresses at or beyond DEPTH never occur; they read as zero.
module adc_value_rom #(
    parameter int DEPTH  = 158,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int BASE   = 0,
    parameter int STEP   = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign tbl[g] = DATA_W'(BASE + g * STEP);
    end

    // Select the addressed entry, guarding the unused top of the range.
    always_comb begin
        data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(addr_i) == i) data_o = tbl[i];
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Conversion sequencer: drives the capacitor pin, paces samples through the
// shared timer, counts samples per phase and forms the table index.
// Assumes comp_i is already synchronised and the timer zero flag becomes
// true exactly the loaded number of edges after a load.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_SAMPLES   = 79,
    parameter int SAMPLE_CYCLES = 60,
    parameter int PAD_CYCLES    = 2,
    parameter int SETTLE_CYCLES = 36000,
    parameter int TMR_W         = 16,
    parameter int IDX_W         = 8,
    parameter int CNT_W         = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             comp_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [TMR_W-1:0] tmr_val_o,
    output logic             pin_o,
    output logic             fire_o,
    output logic [IDX_W-1:0] cap_idx_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_SAMPLES - 1);
    localparam logic [IDX_W-1:0] UPPER    = IDX_W'(NUM_SAMPLES);
    localparam logic [TMR_W-1:0] PAD_LD   = TMR_W'(PAD_CYCLES - 1);
    localparam logic [TMR_W-1:0] SMP_LD   = TMR_W'(SAMPLE_CYCLES - 1);
    localparam logic [TMR_W-1:0] SET_LD   = TMR_W'(SETTLE_CYCLES - 1);

    seq_state_t       state_q, state_d;
    logic             pin_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] cap_q, cap_d;

    // Next-state, timer loads and index formation.
    always_comb begin
        state_d    = state_q;
        pin_d      = pin_o;
        cnt_d      = cnt_q;
        cap_d      = cap_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        fire_o     = 1'b0;
        case (state_q)
            SQ_POWERUP: begin
                if (tmr_zero_i) state_d = SQ_IDLE;
            end
            SQ_IDLE: begin
                if (start_i) begin
                    state_d    = SQ_CHARGE;
                    pin_d      = 1'b1;
                    cnt_d      = '0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = PAD_LD;
                end
            end
            SQ_CHARGE: begin
                if (tmr_zero_i) begin
                    tmr_load_o = 1'b1;
                    if (comp_i) begin
                        cap_d     = IDX_W'(cnt_q);
                        pin_d     = 1'b0;
                        state_d   = SQ_EMPTY;
                        tmr_val_o = SET_LD;
                    end else if (cnt_q == LAST_CNT) begin
                        state_d   = SQ_TOPUP;
                        tmr_val_o = SET_LD;
                    end else begin
                        cnt_d     = cnt_q + 1'b1;
                        tmr_val_o = SMP_LD;
                    end
                end
            end
            SQ_TOPUP: begin
                if (tmr_zero_i) begin
                    state_d    = SQ_DRAIN;
                    pin_d      = 1'b0;
                    cnt_d      = '0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = PAD_LD;
                end
            end
            SQ_DRAIN: begin
                if (tmr_zero_i) begin
                    tmr_load_o = 1'b1;
                    if (!comp_i || cnt_q == LAST_CNT) begin
                        cap_d     = IDX_W'(cnt_q) + UPPER;
                        state_d   = SQ_EMPTY;
                        tmr_val_o = SET_LD;
                    end else begin
                        cnt_d     = cnt_q + 1'b1;
                        tmr_val_o = SMP_LD;
                    end
                end
            end
            SQ_EMPTY: begin
                if (tmr_zero_i) begin
                    fire_o  = 1'b1;
                    state_d = SQ_IDLE;
                end
            end
            default: begin
                state_d = SQ_IDLE;
                pin_d   = 1'b0;
            end
        endcase
    end

    // Register sequencer state, pin and phase count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_POWERUP;
            pin_o   <= 1'b0;
            cnt_q   <= '0;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            pin_o   <= pin_d;
            cnt_q   <= cnt_d;
            cap_q   <= cap_d;
        end
    end

    assign cap_idx_o = cap_q;

    AST_PIN_LOW_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE || state_q == SQ_POWERUP || state_q == SQ_EMPTY) |-> !pin_o); // R1
    AST_PIN_HIGH_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_CHARGE || state_q == SQ_TOPUP) |-> pin_o); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT); // R3
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cap_q) < 2 * NUM_SAMPLES); // R5
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_CHARGE && !tmr_zero_i) |=> state_q == SQ_CHARGE); // R9
endmodule

// File: rtl/rc_slope_adc.sv
// RC slope voltage converter top: synchroniser, shared timer, sequencer,
// computed value ROM and the result registers presented with done.
// Assumes an external RC network whose comparator flips monotonically
// within each phase. Result registers move only on the done strobe.
module rc_slope_adc
    import adc_seq_pkg::*;
#(
    parameter int NUM_SAMPLES   = 79,
    parameter int SAMPLE_CYCLES = 60,
    parameter int PAD_CYCLES    = 2,
    parameter int SETTLE_CYCLES = 36000,
    parameter int DATA_W        = 8,
    parameter int ENTRY_BASE    = 0,
    parameter int ENTRY_STEP    = 1,
    parameter int IDX_W         = $clog2(2 * NUM_SAMPLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              comp_i,
    output logic              charge_o,
    output logic              done_o,
    output logic [IDX_W-1:0]  index_o,
    output logic [DATA_W-1:0] value_o
);
    localparam int DEPTH   = 2 * NUM_SAMPLES;
    localparam int CNT_W   = $clog2(NUM_SAMPLES + 1);
    localparam int TMR_MAX = imax(imax(SETTLE_CYCLES, SAMPLE_CYCLES), PAD_CYCLES);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    logic              comp_s;
    logic              tmr_load, tmr_zero, fire;
    logic [TMR_W-1:0]  tmr_val;
    logic [IDX_W-1:0]  cap_idx;
    logic [DATA_W-1:0] rom_data;

    adc_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (comp_i),
        .sync_o  (comp_s)
    );

    adc_tick_timer #(
        .W       (TMR_W),
        .RST_VAL (SETTLE_CYCLES - 1)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    adc_seq_ctrl #(
        .NUM_SAMPLES   (NUM_SAMPLES),
        .SAMPLE_CYCLES (SAMPLE_CYCLES),
        .PAD_CYCLES    (PAD_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .TMR_W         (TMR_W),
        .IDX_W         (IDX_W),
        .CNT_W         (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .comp_i     (comp_s),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .pin_o      (charge_o),
        .fire_o     (fire),
        .cap_idx_o  (cap_idx)
    );

    adc_value_rom #(
        .DEPTH  (DEPTH),
        .ADDR_W (IDX_W),
        .DATA_W (DATA_W),
        .BASE   (ENTRY_BASE),
        .STEP   (ENTRY_STEP)
    ) u_rom (
        .addr_i (cap_idx),
        .data_o (rom_data)
    );

    // Present index and table value together with the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            index_o <= '0;
            value_o <= '0;
        end else begin
            done_o <= fire;
            if (fire) begin
                index_o <= cap_idx;
                value_o <= rom_data;
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(index_o) && $stable(value_o))); // R7
    AST_DONE_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !charge_o); // R6
endmodule

// File: tb/sim_rc_slope_adc.sv
module sim_rc_slope_adc;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 5;
    localparam int P     = 10;
    localparam int PAD   = 4;
    localparam int SET   = 30;
    localparam int DW    = 8;
    localparam int BASE  = 7;
    localparam int STEP  = 29;
    localparam int IW    = $clog2(2 * N);
    localparam int NEVER = 1000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          comp_raw = 1'b0;
    logic          charge, done;
    logic [IW-1:0] index;
    logic [DW-1:0] value;

    int checks = 0;
    int failures = 0;
    int dc = NEVER;
    int dd = 0;
    int pcnt = 0;
    logic last_pin = 1'b0;

    rc_slope_adc #(
        .NUM_SAMPLES   (N),
        .SAMPLE_CYCLES (P),
        .PAD_CYCLES    (PAD),
        .SETTLE_CYCLES (SET),
        .DATA_W        (DW),
        .ENTRY_BASE    (BASE),
        .ENTRY_STEP    (STEP)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .comp_i   (comp_raw),
        .charge_o (charge),
        .done_o   (done),
        .index_o  (index),
        .value_o  (value)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Comparator model: trips dc cycles after a rise, releases dd cycles after a fall.
    always @(negedge clk) begin
        if (charge !== last_pin) pcnt = 0;
        else if (pcnt < NEVER) pcnt = pcnt + 1;
        last_pin = charge;
        comp_raw = charge ? (pcnt >= dc) : (pcnt < dd);
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int trip_delay(input int k);
        return (k == 0) ? 0 : PAD + k * P - P / 2;
    endfunction

    // One conversion with measured pin durations and result checks.
    task automatic run_conv(input string req, input int dcv, input int ddv, input int exp_idx,
                            input int exp_hi, input int exp_lo, input bit poke);
        int hi = 0;
        int lo = 0;
        int guard = 0;
        bit stable_ok = 1'b1;
        logic [IW-1:0] prev_idx;
        logic [DW-1:0] prev_val;
        @(negedge clk);
        dc = dcv;
        dd = ddv;
        repeat (3) @(negedge clk);
        prev_idx = index;
        prev_val = value;
        start = 1'b1;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (done === 1'b1 || guard > 5000) break;
            guard++;
            if (charge) hi++;
            else if (hi > 0) lo++;
            if (poke && ((charge && hi == 3) || (!charge && lo == 3))) start = 1'b1;
            if (index !== prev_idx || value !== prev_val) stable_ok = 1'b0;
        end
        start = 1'b0;
        check(req, "index", int'(index), exp_idx);
        check("R8", "value", int'(value), (BASE + exp_idx * STEP) % (1 << DW));
        check(req, "pin high cycles", hi, exp_hi);
        check("R6", "pin low cycles before done", lo, exp_lo);
        check("R7", "result stable while busy", int'(stable_ok), 1);
        @(negedge clk);
        check("R7", "done width", int'(done), 0);
    endtask

    initial begin
        int seen_hi = 0;
        repeat (4) @(negedge clk);
        check("R1", "pin in reset", int'(charge), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "index in reset", int'(index), 0);
        check("R1", "value in reset", int'(value), 0);
        rst_n = 1'b1;
        // R1: start during the power-up wait is ignored
        for (int c = 0; c < SET + 4; c++) begin
            @(negedge clk);
            start = (c == 2);
            if (charge) seen_hi++;
        end
        start = 1'b0;
        check("R1", "pin high during power-up wait", seen_hi, 0);
        check("R1", "done during power-up wait", int'(done), 0);

        // R2: charge-phase trip at every sample position
        for (int k = 0; k < N; k++) begin
            run_conv("R2", trip_delay(k), 0, k, PAD + k * P, SET, k == 2);
        end
        // R3 R4: charge timeout then discharge trip at every sample position
        for (int k = 0; k < N; k++) begin
            run_conv("R4", NEVER, trip_delay(k), N + k, PAD + (N - 1) * P + SET,
                     PAD + k * P + SET, k == 3);
        end
        // R5: both phases time out
        run_conv("R5", NEVER, NEVER, 2 * N - 1, PAD + (N - 1) * P + SET,
                 PAD + (N - 1) * P + SET, 1'b0);
        // R9: busy pokes once more, on a charge trip late in the window
        run_conv("R9", trip_delay(N - 1), 0, N - 1, PAD + (N - 1) * P, SET, 1'b1);

        // R7: result holds after done with no start
        dd = 0;
        repeat (25) @(negedge clk);
        check("R7", "index held", int'(index), N - 1);
        check("R3", "pin idle low", int'(charge), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule